// File: doc/BRIEF.md
# Configurable-Edge Quadrature Encoder Counter

This block counts transitions on two external inputs, called phase A and phase B, that arrive with no timing relationship to the counter clock. Each input first passes through a flop synchroniser, and then an edge detector compares it with its previous synchronised level. In pulse mode the counter steps up on the selected edge of phase A and pays no attention to phase B. In quadrature mode each selected edge on one phase steps the counter up or down, and the level of the other phase picks which way. With one active edge the counter steps twice per encoder cycle; with both edges it steps four times.

The count runs from zero up to a programmable limit and wraps in both directions. The mode, the edge selection and the limit are loaded through one write strobe. A load is taken only while the counter is disabled. A load attempted while the counter is enabled is dropped and raises a one-cycle busy indication. While disabled, the counter holds at zero. A direction output gives the sign of the most recent step.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (up) and busy is 0. The loaded settings after reset are pulse mode, rising edge and a limit of 0xFFFF, the largest 16-bit value.
- R2: In pulse mode (cfg_quad=0) the count steps up by one on each selected edge of phase A. Edges on phase B have no effect.
- R3: The edge selection cfg_edge is encoded as 0 = rising, 1 = falling, 2 = both; code 3 behaves like 2. Edges of a type that is not selected produce no step.
- R4: In quadrature mode with rising edges selected: a rising A with B low counts up, and with B high counts down. A rising B with A high counts up, and with A low counts down.
- R5: In quadrature mode with falling edges selected: a falling A with B high counts up, and with B low counts down. A falling B with A low counts up, and with A high counts down.
- R6: In quadrature mode, one full encoder cycle gives 4 steps with both edges selected and 2 steps with a single edge selected.
- R7: A step up from the limit gives 0. A step down from 0 gives the limit.
- R8: A cfg_we pulse while enable is high changes no setting, and busy reads 1 in the cycle after it. Otherwise busy reads 0.
- R9: While enable is low the count is held at 0 and input edges are ignored. Settings loaded with cfg_we in that state take effect once the counter is enabled.
- R10: In quadrature mode, if both synchronised phases change in the same clock cycle, no step is made.
- R11: count_down is 1 after a down step and 0 after an up step, and it holds between steps.
- R12: A change on an input shows on count at the third rising clock edge after it is applied. Before that edge the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Counting enable; low holds the count at zero |
| cfg_we | input | 1 | Load strobe for the mode, edge and limit settings |
| cfg_quad | input | 1 | 0 = pulse mode, 1 = quadrature mode |
| cfg_edge | input | 2 | Active edge: 0 rising, 1 falling, 2 or 3 both |
| cfg_limit | input | CNT_W | Wrap limit (upper end of the count range) |
| in_a | input | 1 | Phase A input, asynchronous |
| in_b | input | 1 | Phase B input, asynchronous |
| count | output | CNT_W | Current count |
| count_down | output | 1 | Sign of the last step, 1 = down |
| busy | output | 1 | A load was attempted while enabled in the previous cycle |

## Verification
The bench builds the block with its defaults: a 16-bit count and a two-flop synchroniser. This puts the three-edge input latency and the full 0xFFFF reset limit within reach. Small programmed limits, down to zero, make both wrap directions reachable in a few steps. Random segments with randomly chosen modes, edge codes (code 3 included) and limits mix single-phase Gray steps with steps where both phases move at once. Directed cases cover the busy rejection, the disabled state and the number of steps per encoder cycle.

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic             cfg_quad,
  input  logic [1:0]       cfg_edge,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic             in_a,
  input  logic             in_b,
  output logic [CNT_W-1:0] count,
  output logic             count_down,
  output logic             busy
);

  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] a_sync, b_sync;
  logic                   a_q, b_q;
  logic                   quad_q;
  logic [1:0]             edge_q;
  logic [CNT_W-1:0]       limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sync <= '0;
      b_sync <= '0;
      a_q    <= 1'b0;
      b_q    <= 1'b0;
    end else begin
      a_sync <= {a_sync[SYNC_STAGES-2:0], in_a};
      b_sync <= {b_sync[SYNC_STAGES-2:0], in_b};
      a_q    <= a_sync[SYNC_STAGES-1];
      b_q    <= b_sync[SYNC_STAGES-1];
    end
  end

  wire a_lvl  = a_sync[SYNC_STAGES-1];
  wire b_lvl  = b_sync[SYNC_STAGES-1];
  wire a_rise = a_lvl & ~a_q;
  wire a_fall = ~a_lvl & a_q;
  wire b_rise = b_lvl & ~b_q;
  wire b_fall = ~b_lvl & b_q;

  wire rise_on = (edge_q != 2'd1);
  wire fall_on = (edge_q != 2'd0);
  wire a_act   = (a_rise & rise_on) | (a_fall & fall_on);
  wire b_act   = (b_rise & rise_on) | (b_fall & fall_on);
  wire both_chg = (a_rise | a_fall) & (b_rise | b_fall);

  logic step, step_up;
  always_comb begin
    step    = 1'b0;
    step_up = 1'b1;
    if (!quad_q) begin
      step = a_act;
    end else if (!both_chg) begin
      if (a_act) begin
        step    = 1'b1;
        step_up = a_rise ? ~b_lvl : b_lvl;
      end else if (b_act) begin
        step    = 1'b1;
        step_up = b_rise ? a_lvl : ~a_lvl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_q  <= 1'b0;
      edge_q  <= 2'd0;
      limit_q <= MAX_CNT;
      busy    <= 1'b0;
    end else begin
      busy <= cfg_we & enable;
      if (cfg_we && !enable) begin
        quad_q  <= cfg_quad;
        edge_q  <= cfg_edge;
        limit_q <= cfg_limit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      count_down <= 1'b0;
    end else if (!enable) begin
      count <= '0;
    end else if (step) begin
      count_down <= ~step_up;
      if (step_up) count <= (count >= limit_q) ? '0 : count + 1'b1;
      else         count <= (count == '0) ? limit_q : count - 1'b1;
    end
  end

  // R7
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= limit_q);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> count == '0);

  // R8
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && enable) |=> (busy && $stable(limit_q) && $stable(edge_q) && $stable(quad_q)));

  // R2
  pulse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !quad_q && $past(enable)) |->
      (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

  // R11
  pulse_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !quad_q && step) |=> !count_down);

  // R10
  simultaneous_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && quad_q && both_chg) |=> $stable(count));

endmodule

// File: tb/qenc_counter_tb_top.sv
module qenc_counter_tb_top;
  logic clk = 0, rst_n = 0, enable = 0, cfg_we = 0, cfg_quad = 0;
  logic [1:0] cfg_edge = 0;
  logic [15:0] cfg_limit = 0;
  logic in_a = 0, in_b = 0;
  logic [15:0] count;
  logic count_down, busy;

  qenc_counter dut_i (.clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_quad(cfg_quad), .cfg_edge(cfg_edge), .cfg_limit(cfg_limit), .in_a(in_a),
    .in_b(in_b), .count(count), .count_down(count_down), .busy(busy));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  int m_quad = 0, m_edge = 0, m_limit = 16'hFFFF, m_cnt = 0, m_dir = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int step_of(int q, int e, bit pa, bit pb, bit na, bit nb);
    bit ra = !pa && na, fa = pa && !na, rb = !pb && nb, fb = pb && !nb;
    bit ris = (e != 1), fal = (e != 0);
    if (!q) return ((ra && ris) || (fa && fal)) ? 1 : 0;
    if (pa != na && pb != nb) return 0;
    if ((ra && ris) || (fa && fal)) return ra ? (nb ? -1 : 1) : (nb ? 1 : -1);
    if ((rb && ris) || (fb && fal)) return rb ? (na ? 1 : -1) : (na ? -1 : 1);
    return 0;
  endfunction

  task automatic model(int s);
    if (s > 0) begin m_cnt = (m_cnt >= m_limit) ? 0 : m_cnt + 1; m_dir = 0; end
    if (s < 0) begin m_cnt = (m_cnt == 0) ? m_limit : m_cnt - 1; m_dir = 1; end
  endtask

  task automatic move(string tag, bit na, bit nb);
    int s;
    @(negedge clk);
    s = enable ? step_of(m_quad, m_edge, in_a, in_b, na, nb) : 0;
    in_a = na; in_b = nb;
    repeat (4) @(negedge clk);
    model(s);
    chk({tag, " count"}, count, m_cnt);
    chk({tag, " dir"}, count_down, m_dir);
  endtask

  task automatic setup(int q, int e, int lim);
    @(negedge clk); enable = 0;
    @(negedge clk); cfg_we = 1; cfg_quad = q[0]; cfg_edge = e[1:0]; cfg_limit = lim[15:0];
    @(negedge clk); cfg_we = 0; enable = 1;
    m_quad = q; m_edge = e; m_limit = lim; m_cnt = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1 reset count", count, 0);
    chk("R1 reset dir", count_down, 0);
    chk("R1 reset busy", busy, 0);
    rst_n = 1;
    @(negedge clk); enable = 1;
    // R1 reset limit is 0xFFFF, pulse mode, rising edge: count past 0xFFFF never reached but modes checked
    move("R1 R2 pulse rise", 1, 0);
    move("R2 IN2 ignored", 1, 1);
    move("R2 fall no count", 0, 0);
    // R12 latency
    @(negedge clk); c0 = count; in_a = 1;
    repeat (2) @(negedge clk); chk("R12 before third edge", count, c0);
    @(negedge clk); chk("R12 third edge", count, c0 + 1); m_cnt = c0 + 1;
    move("R12 return", 0, 0);
    // R3 falling pulse, both pulse
    setup(0, 1, 100);
    move("R3 fall rise ignored", 1, 0);
    move("R3 fall counts", 0, 0);
    setup(0, 3, 100);
    move("R3 code3 rise", 1, 0);
    move("R3 code3 fall", 0, 0);
    // R4 rising quad
    setup(1, 0, 1000);
    move("R4 A rise B low up", 1, 0);
    move("R4 B rise A high up", 1, 1);
    move("R4 falls ignored", 0, 1);
    move("R4 B fall ignored", 0, 0);
    move("R4 B rise A low down", 0, 1);
    move("R4 A rise B high down", 1, 1);
    // R5 falling quad
    setup(1, 1, 1000);
    move("R5 A fall B high up", 0, 1);
    move("R5 B fall A low up", 0, 0);
    move("R5 rise ignored", 1, 0);
    move("R5 B rise ignored", 1, 1);
    move("R5 B fall A high down", 1, 0);
    move("R5 A fall B low down", 0, 0);
    // R6 counts per cycle
    setup(1, 2, 1000);
    move("R6", 1, 0); move("R6", 1, 1); move("R6", 0, 1); move("R6", 0, 0);
    chk("R6 both edges four per cycle", count, 4);
    setup(1, 0, 1000);
    move("R6", 1, 0); move("R6", 1, 1); move("R6", 0, 1); move("R6", 0, 0);
    chk("R6 single edge two per cycle", count, 2);
    // R10 simultaneous
    move("R10 both change", 1, 1);
    move("R10 both change back", 0, 0);
    // R7 wrap
    setup(0, 0, 5);
    repeat (6) begin move("R7 up wrap", 1, 0); move("R7 up wrap", 0, 0); end
    chk("R7 wrapped to zero", count, 0);
    setup(1, 0, 5);
    move("R7 down from zero loads limit", 0, 1);
    chk("R7 limit after down", count, 5);
    move("R7 limit then up", 0, 0);
    setup(0, 0, 0);
    move("R7 limit zero", 1, 0); move("R7 limit zero", 0, 0);
    // R8 busy
    setup(0, 0, 5);
    repeat (4) begin move("R8 prep", 1, 0); move("R8 prep", 0, 0); end
    @(negedge clk); cfg_we = 1; cfg_limit = 2; cfg_quad = 1;
    @(negedge clk); cfg_we = 0; chk("R8 busy after rejected load", busy, 1);
    @(negedge clk); chk("R8 busy clears", busy, 0);
    move("R8 old limit kept", 1, 0); move("R8 old limit kept", 0, 0);
    chk("R8 count reaches old limit", count, 5);
    move("R8 wrap at old limit", 1, 0);
    // R9 disabled
    @(negedge clk); enable = 0;
    @(negedge clk); chk("R9 count zero when disabled", count, 0); m_cnt = 0;
    move("R9 edge ignored", 0, 0); move("R9 edge ignored", 1, 0);
    in_a = 0; repeat (4) @(negedge clk);
    // random segments
    for (int seg = 0; seg < 12; seg++) begin
      int lim = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 9) : $urandom_range(0, 65535);
      setup($urandom_range(0, 1), $urandom_range(0, 3), lim);
      for (int k = 0; k < 40; k++) begin
        int r = $urandom_range(0, 9);
        bit na = in_a, nb = in_b;
        if (r < 4) na = !na; else if (r < 8) nb = !nb; else if (r == 8) begin na = !na; nb = !nb; end
        move("R2 R4 R5 R7 R10 R11 random", na, nb);
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule